// File: doc/BRIEF.md
# Compressed DFA Byte Walker

The block matches a byte stream against a deterministic automaton whose transition table is stored in compressed form. Every non-root state keeps a short list of labelled transitions and one default pointer; a byte that finds no label in the state follows the default pointer without being consumed and is looked up again in the target. The root state instead owns a complete next-state table with one entry per byte value, so any lookup that reaches the root resolves at once.

Bytes arrive on a valid/ready handshake. Ready stays low for as long as the walker is stepping along a default chain, and goes high in the cycle in which the current byte resolves. For each consumed byte the block reports how many state reads it took, and it pulses a match flag with a rule number whenever the state entered is accepting. The tables are written through two write ports before matching begins: one for the per-state records and one for the root table.

Top module: `dfa_walker`

## Requirements
- R1: While rst_ni is low and after it rises, cur_state_o is 0, match_o is 0, rule_id_o is 0, reads_valid_o is 0 and reads_o is 0.
- R2: A rising clock edge with rec_we_i high stores rec_data_i as the record of state rec_addr_i. Record bits, high to low: [59] accept, [58:55] rule number, [54:51] default state, [50:48] label count, [47:16] four label symbols with label k at [16+8k+7:16+8k], [15:0] four label targets with label k at [4k+3:4k].
- R3: A rising edge with root_we_i high sets the root-table entry for byte root_sym_i to root_next_i. A lookup in state 0 consumes the byte in one read and moves to that entry; the root's labels and default are not used.
- R4: In a non-root state, only labels with index below the label count take part; a byte equal to such a label is consumed in the current read and moves to its target. Where several valid labels carry the byte, the lowest index wins.
- R5: A byte with no valid label in a non-root state is not consumed: byte_ready_o is low, the lookup moves to the default state in the next cycle and the same byte is looked up again there; cur_state_o does not change meanwhile.
- R6: After DP_MAX default steps for one byte, a further miss resolves through the root table in that same read, so no byte costs more than DP_MAX+1 reads.
- R7: In the cycle after a byte is consumed, match_o is 1 exactly when the new state is accepting, and rule_id_o then holds that state's rule number; in every other cycle match_o and rule_id_o are 0.
- R8: In the cycle after a byte is consumed, reads_valid_o is 1 and reads_o equals the number of state reads spent on that byte; otherwise reads_valid_o is 0.
- R9: With byte_valid_i low, byte_i has no effect: state, match and read reporting do not change.
- R10: Rewriting a state record between bytes takes effect for the next lookup of that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rec_we_i | input | 1 | State record write enable |
| rec_addr_i | input | 4 | State record index |
| rec_data_i | input | 60 | State record contents |
| root_we_i | input | 1 | Root table write enable |
| root_sym_i | input | 8 | Root table byte index |
| root_next_i | input | 4 | Root table target state |
| byte_valid_i | input | 1 | Input byte valid |
| byte_i | input | 8 | Input byte |
| byte_ready_o | output | 1 | Byte resolves in this cycle |
| cur_state_o | output | 4 | State after the last consumed byte |
| match_o | output | 1 | Accepting state entered |
| rule_id_o | output | 4 | Rule number of the accepting state |
| reads_valid_o | output | 1 | reads_o is valid |
| reads_o | output | 3 | State reads spent on the last byte |

## Verification
The properties assume that a source holding byte_valid_i high keeps it high with byte_i unchanged until byte_ready_o is seen, because a default chain re-examines the same byte over several cycles; they also assume the tables are not rewritten while a byte is pending. The bench raises valid only between bytes, holds the byte until the handshake completes, and writes records and root entries only with valid low. Random bytes are drawn mostly from the symbols that appear in the loaded tables, so hits, default chains of every length and the forced root fallback all occur.

// File: rtl/dfa_walk_pkg.sv
package dfa_walk_pkg;
  parameter int SYM_W   = 8;
  parameter int STATE_W = 4;
  parameter int LBL_N   = 4;
  parameter int RULE_W  = 4;
  localparam int CNT_W      = $clog2(LBL_N + 1);
  localparam int NUM_STATES = 1 << STATE_W;
  localparam int ROOT_N     = 1 << SYM_W;

  typedef struct packed {
    logic                            acc;
    logic [RULE_W-1:0]               rule;
    logic [STATE_W-1:0]              dflt;
    logic [CNT_W-1:0]                cnt;
    logic [LBL_N-1:0][SYM_W-1:0]     sym;
    logic [LBL_N-1:0][STATE_W-1:0]   nxt;
  } dfa_rec_t;

  localparam int REC_W = $bits(dfa_rec_t);
endpackage

// File: rtl/dfa_state_store.sv
module dfa_state_store
  import dfa_walk_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rec_we_i,
  input  logic [STATE_W-1:0]            rec_addr_i,
  input  dfa_rec_t                      rec_i,
  input  logic                          root_we_i,
  input  logic [SYM_W-1:0]              root_sym_i,
  input  logic [STATE_W-1:0]            root_next_i,
  input  logic [STATE_W-1:0]            look_addr_i,
  output logic [STATE_W-1:0]            look_dflt_o,
  output logic [CNT_W-1:0]              look_cnt_o,
  output logic [LBL_N-1:0][SYM_W-1:0]   look_sym_o,
  output logic [LBL_N-1:0][STATE_W-1:0] look_nxt_o,
  input  logic [SYM_W-1:0]              root_look_i,
  output logic [STATE_W-1:0]            root_next_o,
  input  logic [STATE_W-1:0]            acc_addr_i,
  output logic                          acc_o,
  output logic [RULE_W-1:0]             rule_o
);
  dfa_rec_t           recs_q [NUM_STATES];
  logic [STATE_W-1:0] root_q [ROOT_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_STATES; i++) recs_q[i] <= '0;
      for (int j = 0; j < ROOT_N; j++)     root_q[j] <= '0;
    end else begin
      if (rec_we_i)  recs_q[rec_addr_i] <= rec_i;
      if (root_we_i) root_q[root_sym_i] <= root_next_i;
    end
  end

  assign look_dflt_o = recs_q[look_addr_i].dflt;
  assign look_cnt_o  = recs_q[look_addr_i].cnt;
  assign look_sym_o  = recs_q[look_addr_i].sym;
  assign look_nxt_o  = recs_q[look_addr_i].nxt;
  assign root_next_o = root_q[root_look_i];
  assign acc_o       = recs_q[acc_addr_i].acc;
  assign rule_o      = recs_q[acc_addr_i].rule;
endmodule

// File: rtl/dfa_label_match.sv
module dfa_label_match
  import dfa_walk_pkg::*;
(
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [LBL_N-1:0][SYM_W-1:0]   sym_i,
  input  logic [LBL_N-1:0][STATE_W-1:0] nxt_i,
  input  logic [SYM_W-1:0]              byte_i,
  output logic                          hit_o,
  output logic [STATE_W-1:0]            next_o
);
  logic [LBL_N-1:0] eq;

  for (genvar k = 0; k < LBL_N; k++) begin : g_lbl
    assign eq[k] = (CNT_W'(k) < cnt_i) && (sym_i[k] == byte_i);
  end

  // lowest index has priority
  always_comb begin
    hit_o  = |eq;
    next_o = '0;
    for (int k = LBL_N - 1; k >= 0; k--) begin
      if (eq[k]) next_o = nxt_i[k];
    end
  end
endmodule

// File: rtl/dfa_walk_ctrl.sv
module dfa_walk_ctrl
  import dfa_walk_pkg::*;
#(
  parameter int DP_MAX = 3,
  localparam int HOP_W = (DP_MAX > 0) ? $clog2(DP_MAX + 1) : 1,
  localparam int RD_W  = $clog2(DP_MAX + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               hit_i,
  input  logic [STATE_W-1:0] hit_next_i,
  input  logic [STATE_W-1:0] dflt_i,
  input  logic [STATE_W-1:0] root_next_i,
  input  logic               next_acc_i,
  input  logic [RULE_W-1:0]  next_rule_i,
  output logic [STATE_W-1:0] look_state_o,
  output logic [STATE_W-1:0] next_state_o,
  output logic               ready_o,
  output logic [STATE_W-1:0] cur_state_o,
  output logic               match_o,
  output logic [RULE_W-1:0]  rule_id_o,
  output logic [RD_W-1:0]    reads_o,
  output logic               reads_valid_o
);
  logic [STATE_W-1:0] look_q, cur_q;
  logic [HOP_W-1:0]   hops_q;
  logic               at_root, at_limit, take;

  assign at_root  = (look_q == '0);
  assign at_limit = (hops_q == HOP_W'(DP_MAX));
  assign ready_o  = at_root || hit_i || at_limit;
  assign take     = valid_i && ready_o;
  // root and the depth limit both resolve through the full root table
  assign next_state_o = (!at_root && hit_i) ? hit_next_i : root_next_i;
  assign look_state_o = look_q;
  assign cur_state_o  = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      look_q        <= '0;
      cur_q         <= '0;
      hops_q        <= '0;
      match_o       <= 1'b0;
      rule_id_o     <= '0;
      reads_o       <= '0;
      reads_valid_o <= 1'b0;
    end else begin
      match_o       <= 1'b0;
      rule_id_o     <= '0;
      reads_valid_o <= 1'b0;
      if (take) begin
        look_q        <= next_state_o;
        cur_q         <= next_state_o;
        hops_q        <= '0;
        match_o       <= next_acc_i;
        rule_id_o     <= next_acc_i ? next_rule_i : '0;
        reads_o       <= RD_W'(hops_q) + RD_W'(1);
        reads_valid_o <= 1'b1;
      end else if (valid_i) begin
        look_q <= dflt_i;
        hops_q <= hops_q + HOP_W'(1);
      end
    end
  end
endmodule

// File: rtl/dfa_walker.sv
module dfa_walker
  import dfa_walk_pkg::*;
#(
  parameter int DP_MAX = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rec_we_i,
  input  logic [STATE_W-1:0]            rec_addr_i,
  input  logic [REC_W-1:0]              rec_data_i,
  input  logic                          root_we_i,
  input  logic [SYM_W-1:0]              root_sym_i,
  input  logic [STATE_W-1:0]            root_next_i,
  input  logic                          byte_valid_i,
  input  logic [SYM_W-1:0]              byte_i,
  output logic                          byte_ready_o,
  output logic [STATE_W-1:0]            cur_state_o,
  output logic                          match_o,
  output logic [RULE_W-1:0]             rule_id_o,
  output logic                          reads_valid_o,
  output logic [$clog2(DP_MAX+2)-1:0]   reads_o
);
  logic [STATE_W-1:0]            look_state, next_state, look_dflt, root_next, hit_next;
  logic [CNT_W-1:0]              look_cnt;
  logic [LBL_N-1:0][SYM_W-1:0]   look_sym;
  logic [LBL_N-1:0][STATE_W-1:0] look_nxt;
  logic                          hit, next_acc;
  logic [RULE_W-1:0]             next_rule;

  dfa_state_store u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rec_we_i    (rec_we_i),
    .rec_addr_i  (rec_addr_i),
    .rec_i       (dfa_rec_t'(rec_data_i)),
    .root_we_i   (root_we_i),
    .root_sym_i  (root_sym_i),
    .root_next_i (root_next_i),
    .look_addr_i (look_state),
    .look_dflt_o (look_dflt),
    .look_cnt_o  (look_cnt),
    .look_sym_o  (look_sym),
    .look_nxt_o  (look_nxt),
    .root_look_i (byte_i),
    .root_next_o (root_next),
    .acc_addr_i  (next_state),
    .acc_o       (next_acc),
    .rule_o      (next_rule)
  );

  dfa_label_match u_match (
    .cnt_i  (look_cnt),
    .sym_i  (look_sym),
    .nxt_i  (look_nxt),
    .byte_i (byte_i),
    .hit_o  (hit),
    .next_o (hit_next)
  );

  dfa_walk_ctrl #(.DP_MAX(DP_MAX)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (byte_valid_i),
    .hit_i         (hit),
    .hit_next_i    (hit_next),
    .dflt_i        (look_dflt),
    .root_next_i   (root_next),
    .next_acc_i    (next_acc),
    .next_rule_i   (next_rule),
    .look_state_o  (look_state),
    .next_state_o  (next_state),
    .ready_o       (byte_ready_o),
    .cur_state_o   (cur_state_o),
    .match_o       (match_o),
    .rule_id_o     (rule_id_o),
    .reads_o       (reads_o),
    .reads_valid_o (reads_valid_o)
  );
endmodule

// File: rtl/dfa_walker_chk.sv
module dfa_walker_chk
  import dfa_walk_pkg::*;
#(
  parameter int DP_MAX = 3
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        byte_valid_i,
  input logic [SYM_W-1:0]            byte_i,
  input logic                        byte_ready_o,
  input logic [STATE_W-1:0]          cur_state_o,
  input logic                        match_o,
  input logic [RULE_W-1:0]           rule_id_o,
  input logic                        reads_valid_o,
  input logic [$clog2(DP_MAX+2)-1:0] reads_o
);
  // R5 input contract: a stalled byte is held
  hold_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && !byte_ready_o |=> byte_valid_i && $stable(byte_i));

  // R5
  stall_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && !byte_ready_o |=> $stable(cur_state_o) && !reads_valid_o);

  // R6
  read_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reads_valid_o |-> (int'(reads_o) >= 1) && (int'(reads_o) <= DP_MAX + 1));

  // R7
  match_rpt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> reads_valid_o);

  // R7
  rule_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> rule_id_o == '0);

  // R8
  take_rpt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && byte_ready_o |=> reads_valid_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> !reads_valid_o && !match_o && $stable(cur_state_o));
endmodule

bind dfa_walker dfa_walker_chk #(.DP_MAX(DP_MAX)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .byte_valid_i  (byte_valid_i),
  .byte_i        (byte_i),
  .byte_ready_o  (byte_ready_o),
  .cur_state_o   (cur_state_o),
  .match_o       (match_o),
  .rule_id_o     (rule_id_o),
  .reads_valid_o (reads_valid_o),
  .reads_o       (reads_o)
);

// File: tb/tb_dfa_walker.sv
module tb_dfa_walker;
  import dfa_walk_pkg::*;
  localparam int DP   = 3;
  localparam int RD_W = $clog2(DP + 2);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                rst_n;
  logic                rec_we, root_we, valid;
  logic [STATE_W-1:0]  rec_addr, root_next;
  logic [REC_W-1:0]    rec_data;
  logic [SYM_W-1:0]    root_sym, din;
  logic                ready, match, rvalid;
  logic [STATE_W-1:0]  cur;
  logic [RULE_W-1:0]   rule;
  logic [RD_W-1:0]     reads;

  dfa_walker #(.DP_MAX(DP)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rec_we_i(rec_we), .rec_addr_i(rec_addr), .rec_data_i(rec_data),
    .root_we_i(root_we), .root_sym_i(root_sym), .root_next_i(root_next),
    .byte_valid_i(valid), .byte_i(din), .byte_ready_o(ready),
    .cur_state_o(cur), .match_o(match), .rule_id_o(rule),
    .reads_valid_o(rvalid), .reads_o(reads)
  );

  // bench model of the tables
  bit   m_acc  [NUM_STATES];
  int   m_rule [NUM_STATES];
  int   m_dflt [NUM_STATES];
  int   m_cnt  [NUM_STATES];
  int   m_sym  [NUM_STATES][LBL_N];
  int   m_nxt  [NUM_STATES][LBL_N];
  int   m_root [ROOT_N];
  int   m_cur;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic set_state(int s, bit acc, int rl, int dflt, int cnt);
    m_acc[s] = acc; m_rule[s] = rl; m_dflt[s] = dflt; m_cnt[s] = cnt;
  endtask

  task automatic set_lbl(int s, int k, int sym, int nxt);
    m_sym[s][k] = sym; m_nxt[s][k] = nxt;
  endtask

  task automatic wr_state(int s);
    dfa_rec_t r;
    r.acc  = m_acc[s];
    r.rule = RULE_W'(m_rule[s]);
    r.dflt = STATE_W'(m_dflt[s]);
    r.cnt  = CNT_W'(m_cnt[s]);
    for (int k = 0; k < LBL_N; k++) begin
      r.sym[k] = SYM_W'(m_sym[s][k]);
      r.nxt[k] = STATE_W'(m_nxt[s][k]);
    end
    @(negedge clk);
    rec_data = r; rec_addr = STATE_W'(s); rec_we = 1'b1;
    @(negedge clk);
    rec_we = 1'b0;
  endtask

  task automatic wr_root();
    for (int b = 0; b < ROOT_N; b++) begin
      @(negedge clk);
      root_we = 1'b1; root_sym = SYM_W'(b); root_next = STATE_W'(m_root[b]);
    end
    @(negedge clk);
    root_we = 1'b0;
  endtask

  // expected walk from the requirements
  task automatic model(int b, output int nx, output int rd);
    int s;
    s = m_cur; nx = 0; rd = 0;
    for (int h = 0; h <= DP; h++) begin
      if (s == 0) begin nx = m_root[b]; rd = h + 1; return; end
      for (int k = 0; k < m_cnt[s]; k++) begin
        if (m_sym[s][k] == b) begin nx = m_nxt[s][k]; rd = h + 1; return; end
      end
      if (h == DP) begin nx = m_root[b]; rd = h + 1; return; end
      s = m_dflt[s];
    end
  endtask

  task automatic send(int b);
    int  nx, rd, cyc;
    bit  r, stall_bad;
    model(b, nx, rd);
    @(negedge clk);
    valid = 1'b1; din = SYM_W'(b);
    cyc = 0; stall_bad = 1'b0;
    do begin
      #1 r = ready;
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (!r && (rvalid || cur != STATE_W'(m_cur))) stall_bad = 1'b1;
    end while (!r && cyc < 32);
    valid = 1'b0;
    chk("R5 cycles per byte", cyc, rd);
    chk("R5 stall quiet", int'(stall_bad), 0);
    chk("R8 reads_valid", int'(rvalid), 1);
    chk("R8 reads", int'(reads), rd);
    chk("R4 next state", int'(cur), nx);
    chk("R7 match", int'(match), int'(m_acc[nx]));
    chk("R7 rule", int'(rule), m_acc[nx] ? m_rule[nx] : 0);
    m_cur = nx;
  endtask

  task automatic idle(int junk);
    @(negedge clk);
    din = SYM_W'(junk);
    @(negedge clk);
    chk("R9 idle state", int'(cur), m_cur);
    chk("R7 pulse dropped", int'(match), 0);
    chk("R9 no report", int'(rvalid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    string alpha;
    void'($urandom(32'd4711));
    alpha = "abcdeqrxyz";
    rst_n = 1'b0; rec_we = 1'b0; root_we = 1'b0; valid = 1'b0;
    rec_addr = '0; rec_data = '0; root_sym = '0; root_next = '0; din = '0;
    for (int s = 0; s < NUM_STATES; s++) begin
      set_state(s, 1'b0, 0, 0, 0);
      for (int k = 0; k < LBL_N; k++) set_lbl(s, k, 0, 0);
    end
    for (int b = 0; b < ROOT_N; b++) m_root[b] = 0;
    m_cur = 0;
    repeat (3) @(negedge clk);
    chk("R1 state in reset", int'(cur), 0);
    chk("R1 match in reset", int'(match), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state", int'(cur), 0);
    chk("R1 rule", int'(rule), 0);
    chk("R1 reads_valid", int'(rvalid), 0);
    chk("R1 reads", int'(reads), 0);

    m_root["a"] = 1; m_root["b"] = 4; m_root["q"] = 6; m_root["r"] = 7;
    set_state(1, 1'b0, 0, 0, 3);
    set_lbl(1, 0, "b", 2); set_lbl(1, 1, "b", 5); set_lbl(1, 2, "a", 1);
    set_state(2, 1'b1, 5, 4, 1); set_lbl(2, 0, "c", 3);
    set_state(3, 1'b1, 9, 0, 0); set_lbl(3, 0, "e", 5);
    set_state(4, 1'b0, 0, 0, 1); set_lbl(4, 0, "d", 5);
    set_state(5, 1'b1, 3, 0, 0);
    set_state(6, 1'b0, 0, 2, 1); set_lbl(6, 0, "z", 5);
    set_state(7, 1'b0, 0, 6, 1); set_lbl(7, 0, "y", 3);
    for (int s = 0; s < 8; s++) wr_state(s);   // R2
    wr_root();                                  // R3

    send("a"); chk("R3 root step", int'(cur), 1);
    send("b"); chk("R4 lowest label wins", int'(cur), 2);
    chk("R2 rule field", int'(rule), 5);
    idle("c");
    send("c"); chk("R7 accept rule", int'(rule), 9);
    send("e"); chk("R4 label past count ignored", int'(cur), 0);
    send("b"); send("d"); chk("R2 accept bit", int'(match), 1);
    send("r"); chk("R5 default then root", int'(reads), 2);
    send("x"); chk("R6 capped reads", int'(reads), DP + 1);
    chk("R6 capped target", int'(cur), 0);
    send("a"); send("b");
    send("d"); chk("R5 chain hit", int'(reads), 2);
    idle("z");
    set_state(5, 1'b1, 7, 0, 0);
    wr_state(5);
    send("b"); send("d"); chk("R10 rewritten rule", int'(rule), 7);

    for (int i = 0; i < 400; i++) begin
      int b;
      if (($urandom % 5) != 0) b = int'(alpha[$urandom % alpha.len()]);
      else b = int'($urandom % ROOT_N);
      send(b);
      if (($urandom % 4) == 0) idle(int'($urandom % ROOT_N));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule